// File: doc/BRIEF.md
# ADC conversion start and auto-trigger controller

This block sits in front of an analog-to-digital conversion engine and decides when a conversion begins. Software can begin a single conversion by writing one to a start bit. With auto-triggering on, the block instead watches one of eight trigger sources, chosen by a 3-bit select, and begins a conversion on a rising edge of that source. When a conversion begins, the block emits a one-cycle start pulse. It also captures the requested channel into a shadow register, which is the only channel value the engine sees. For trigger-caused starts it resets the conversion clock prescaler.

Source 0 is not an external pin. It is the block's own conversion-complete flag. The engine's `conv_done` pulse sets this flag whether or not any interrupt is enabled. Software clears it with `flag_clr`. Because a flag that stays set shows no new rising edge, a flag-driven trigger fires again only after software has cleared the flag and a later completion has set it again.

The controller is a three-state machine:
- **IDLE**: no conversion is running.
- **LAUNCH**: lasts one cycle; the start pulse is issued.
- **CONV**: waits for `conv_done`.

Transitions:
- **IDLE→LAUNCH** occurs on a software start or a qualified trigger edge while enabled.
- **LAUNCH→CONV** occurs unconditionally.
- **CONV→IDLE** occurs on completion.
- **any→IDLE** occurs when the enable bit drops. This is an abort.

Top module: `adc_start_ctrl`

## Requirements
- R1: While `enable` is low no start pulse is issued; dropping `enable` during a conversion returns the block to idle, with `busy` low from the next cycle.
- R2: A `start_wr` pulse sampled while idle and enabled gives `start_pulse` high for exactly the next cycle. `busy` is high from that cycle until the cycle after `conv_done` is sampled in CONV. `start_wr` while busy is ignored.
- R3: `chan_active` takes the value of `chan_sel` at the start and holds it for the whole conversion, even if `chan_sel` changes meanwhile.
- R4: With `auto_en` high, a selected source found high one cycle after being low gives `start_pulse` and `presc_rst` together in the following cycle. `presc_rst` is never high without `start_pulse`, and a software start leaves it low.
- R5: Trigger edges that arrive while `busy` is high are ignored and not queued: no start follows once the conversion ends.
- R6: A trigger level still high when the conversion completes does not start a new conversion.
- R7: Changing `trig_sel` to a source that is already high produces no start.
- R8: `done_flag` becomes 1 in the cycle after `conv_done` is sampled in CONV. `flag_clr` clears it. If both happen together, the set wins.
- R9: With `trig_sel`=0 (the completion flag) and `auto_en` high, a conversion starts the cycle after the flag rises. No further start happens until the flag is cleared and set again.
- R10: After reset, `start_pulse`, `presc_rst`, `busy`, `done_flag` and `chan_active` are all 0.
- R11: With `auto_en` low, trigger edges are ignored. Selects 1 to 7 map to `trig_ext[0]` to `trig_ext[6]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter enable bit |
| start_wr | input | 1 | Software write of one to the start bit |
| auto_en | input | 1 | Auto-trigger enable |
| trig_sel | input | 3 | Trigger source select; 0 is the completion flag |
| trig_ext | input | 7 | External trigger sources for selects 1 to 7 |
| flag_clr | input | 1 | Software clear of the completion flag |
| chan_sel | input | 5 | Requested input channel |
| conv_done | input | 1 | Completion pulse from the engine |
| start_pulse | output | 1 | One-cycle conversion start |
| presc_rst | output | 1 | Prescaler reset for trigger-caused starts |
| chan_active | output | 5 | Shadowed channel used by the engine |
| busy | output | 1 | Start bit readback, high during a conversion |
| done_flag | output | 1 | Conversion-complete flag |

## Verification
The hardest situation to reach is the flag-sourced retrigger rule. A software start is used to produce a first completion, which raises the flag and launches an automatic conversion. That conversion is then completed without clearing the flag, and the bench checks that no third start follows. Edges during a conversion and held-high trigger levels are produced by toggling each external source in turn while a conversion it started is still running. A select change is driven onto a source that is already high.

// File: rtl/adc_sc_pkg.sv
package adc_sc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_CONV   = 2'd2
    } adc_sc_state_t;
endpackage

// File: rtl/adc_sc_trig.sv
module adc_sc_trig #(
    parameter int N_TRIG   = 8,
    parameter int SEL_W    = $clog2(N_TRIG),
    parameter int FLAG_SRC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRIG-2:0] trig_ext,
    input  logic              flag_i,
    input  logic [SEL_W-1:0]  sel,
    output logic              edge_o
);
    logic [N_TRIG-1:0] src;
    logic              prev_q;
    logic [SEL_W-1:0]  sel_q;

    // Map the completion flag into slot FLAG_SRC, externals around it.
    for (genvar g = 0; g < N_TRIG; g++) begin : g_src
        if (g == FLAG_SRC) begin : g_flag
            assign src[g] = flag_i;
        end else if (g < FLAG_SRC) begin : g_lo
            assign src[g] = trig_ext[g];
        end else begin : g_hi
            assign src[g] = trig_ext[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            prev_q <= src[sel];
            sel_q  <= sel;
        end
    end

    // An edge counts only when the select was steady across the sample pair.
    assign edge_o = src[sel] & ~prev_q & (sel == sel_q);
endmodule

// File: rtl/adc_sc_flag.sv
module adc_sc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_flag_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/adc_sc_fsm.sv
module adc_sc_fsm
    import adc_sc_pkg::*;
#(
    parameter int CH_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            start_wr,
    input  logic            auto_en,
    input  logic            trig_edge,
    input  logic [CH_W-1:0] chan_sel,
    input  logic            conv_done,
    output logic            start_pulse,
    output logic            presc_rst,
    output logic            busy,
    output logic [CH_W-1:0] chan_active,
    output logic            done_evt
);
    adc_sc_state_t state_q, state_d;
    logic          sw_go, hw_go, by_trig_q;

    assign sw_go = enable && start_wr;
    assign hw_go = enable && auto_en && trig_edge;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sw_go || hw_go) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_CONV;
            ST_CONV:   if (conv_done)      state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (!enable) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            chan_active <= '0;
            by_trig_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_LAUNCH) begin
                chan_active <= chan_sel;
                by_trig_q   <= !sw_go;
            end
        end
    end

    always_comb begin
        start_pulse = (state_q == ST_LAUNCH);
        presc_rst   = (state_q == ST_LAUNCH) && by_trig_q;
        busy        = (state_q != ST_IDLE);
        done_evt    = (state_q == ST_CONV) && conv_done && enable;
    end

    assert_no_start_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!start_pulse && !busy));
    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && enable && !conv_done) |=> busy);
    assert_chan_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(chan_active));
    assert_presc_with_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        presc_rst |-> start_pulse);
    assert_no_restart_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !start_pulse);
    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> !busy);
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl #(
    parameter int N_TRIG   = 8,
    parameter int CH_W     = 5,
    parameter int FLAG_SRC = 0,
    localparam int SEL_W   = $clog2(N_TRIG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start_wr,
    input  logic              auto_en,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic [N_TRIG-2:0] trig_ext,
    input  logic              flag_clr,
    input  logic [CH_W-1:0]   chan_sel,
    input  logic              conv_done,
    output logic              start_pulse,
    output logic              presc_rst,
    output logic [CH_W-1:0]   chan_active,
    output logic              busy,
    output logic              done_flag
);
    logic trig_edge, done_evt;

    adc_sc_trig #(.N_TRIG(N_TRIG), .SEL_W(SEL_W), .FLAG_SRC(FLAG_SRC)) u_trig (
        .clk(clk), .rst_n(rst_n), .trig_ext(trig_ext), .flag_i(done_flag),
        .sel(trig_sel), .edge_o(trig_edge)
    );

    adc_sc_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(done_evt), .clr_i(flag_clr), .flag_o(done_flag)
    );

    adc_sc_fsm #(.CH_W(CH_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_wr(start_wr),
        .auto_en(auto_en), .trig_edge(trig_edge), .chan_sel(chan_sel),
        .conv_done(conv_done), .start_pulse(start_pulse), .presc_rst(presc_rst),
        .busy(busy), .chan_active(chan_active), .done_evt(done_evt)
    );

    // R9: a flag-sourced start needs the flag to have risen, so it cannot launch while the flag was already high.
    assert_flag_src_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && auto_en && enable && !start_wr && trig_sel == SEL_W'(FLAG_SRC)
         && done_flag && $stable(done_flag) && $stable(trig_sel)) |=> !start_pulse);
endmodule

// File: tb/tb_adc_start_ctrl.sv
`timescale 1ns/1ps
module tb_adc_start_ctrl;
    logic       clk = 1'b0;
    logic       rst_n, enable, start_wr, auto_en, flag_clr, conv_done;
    logic [2:0] trig_sel;
    logic [6:0] trig_ext;
    logic [4:0] chan_sel;
    logic       start_pulse, presc_rst, busy, done_flag;
    logic [4:0] chan_active;
    int         n_run = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    adc_start_ctrl dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_wr(start_wr),
        .auto_en(auto_en), .trig_sel(trig_sel), .trig_ext(trig_ext),
        .flag_clr(flag_clr), .chan_sel(chan_sel), .conv_done(conv_done),
        .start_pulse(start_pulse), .presc_rst(presc_rst), .chan_active(chan_active),
        .busy(busy), .done_flag(done_flag)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; enable = 0; start_wr = 0; auto_en = 0; flag_clr = 0;
        conv_done = 0; trig_sel = 0; trig_ext = 0; chan_sel = 0;
        step(); step();
        chk("R10 start_pulse", start_pulse, 0);
        chk("R10 presc_rst", presc_rst, 0);
        chk("R10 busy", busy, 0);
        chk("R10 done_flag", done_flag, 0);
        chk("R10 chan_active", chan_active, 0);
        rst_n = 1; step();

        // R1: start while disabled is refused
        start_wr = 1; step();
        chk("R1 start disabled", start_pulse, 0);
        chk("R1 busy disabled", busy, 0);
        start_wr = 0; enable = 1; step();

        // R2/R3/R8 sweep over every channel
        for (int ch = 0; ch < 32; ch++) begin
            chan_sel = 5'(ch); start_wr = 1; step();
            chk("R2 start", start_pulse, 1);
            chk("R2 busy", busy, 1);
            chk("R4 sw no presc", presc_rst, 0);
            chk("R3 latch", chan_active, ch);
            start_wr = 0; chan_sel = ~5'(ch); step();
            chk("R2 one cycle", start_pulse, 0);
            chk("R2 busy hold", busy, 1);
            start_wr = 1; step();
            chk("R2 ignored while busy", start_pulse, 0);
            chk("R3 hold", chan_active, ch);
            start_wr = 0; conv_done = 1; step();
            conv_done = 0;
            chk("R2 cleared", busy, 0);
            chk("R8 flag set", done_flag, 1);
            chk("R3 hold after", chan_active, ch);
            flag_clr = 1; step(); flag_clr = 0;
            chk("R8 flag clr", done_flag, 0);
        end

        // R8: set wins over clear
        start_wr = 1; step(); start_wr = 0; step();
        conv_done = 1; flag_clr = 1; step(); conv_done = 0; flag_clr = 0;
        chk("R8 set wins", done_flag, 1);
        flag_clr = 1; step(); flag_clr = 0;

        // R1: abort
        start_wr = 1; step(); start_wr = 0; step();
        enable = 0; step();
        chk("R1 abort", busy, 0);
        enable = 1; step();

        // R4/R5/R6 per external source
        auto_en = 1;
        for (int s = 1; s < 8; s++) begin
            trig_sel = 3'(s); chan_sel = 5'(s + 8); step(); step();
            trig_ext[s-1] = 1; step();
            chk("R4 trig start", start_pulse, 1);
            chk("R4 presc", presc_rst, 1);
            chk("R3 trig chan", chan_active, s + 8);
            step();
            trig_ext[s-1] = 0; step();
            trig_ext[s-1] = 1; step();
            chk("R5 edge ignored", start_pulse, 0);
            conv_done = 1; step(); conv_done = 0;
            chk("R2 done", busy, 0);
            step(); step();
            chk("R6 level no start", start_pulse, 0);
            chk("R5 not queued", busy, 0);
            trig_ext[s-1] = 0; flag_clr = 1; step(); flag_clr = 0; step();
        end

        // R11: auto off
        auto_en = 0; trig_sel = 3; step();
        trig_ext[2] = 1; step();
        chk("R11 auto off", start_pulse, 0);
        step();
        chk("R11 auto off busy", busy, 0);
        trig_ext = 0; auto_en = 1;

        // R1: trigger while disabled
        enable = 0; step(); trig_ext[2] = 1; step();
        chk("R1 trig disabled", start_pulse, 0);
        trig_ext = 0; enable = 1; step();

        // R7: select change onto high source
        trig_sel = 1; trig_ext = 7'b0000010; step(); step();
        trig_sel = 2; step();
        chk("R7 sel change", start_pulse, 0);
        step();
        chk("R7 sel change later", start_pulse, 0);
        chk("R7 busy", busy, 0);
        trig_ext = 0; step();

        // R9: flag source
        trig_sel = 0; step(); step();
        start_wr = 1; step(); start_wr = 0; step();
        conv_done = 1; step(); conv_done = 0;
        chk("R9 idle after done", busy, 0);
        step();
        chk("R9 flag start", start_pulse, 1);
        chk("R9 flag presc", presc_rst, 1);
        step();
        conv_done = 1; step(); conv_done = 0;
        step(); step();
        chk("R9 no retrigger", start_pulse, 0);
        chk("R9 idle", busy, 0);
        chk("R9 flag held", done_flag, 1);
        flag_clr = 1; step(); flag_clr = 0;
        chk("R9 cleared", done_flag, 0);
        step();
        chk("R9 clear no start", busy, 0);
        start_wr = 1; step(); start_wr = 0; step();
        conv_done = 1; step(); conv_done = 0; step();
        chk("R9 retrigger after clear", start_pulse, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule